// File: doc/BRIEF.md
# Arithmetic right shift execute unit

This block is the execute stage for a single signed-shift instruction. A one-cycle start pulse hands it a 32-bit instruction word together with the current value of the destination register and the value of the source register. The block checks the opcode and decodes the remaining fields. It shifts the destination value right, filling the vacated high bits with copies of its sign bit. The shift count is 0 to 31. It comes either from the low five bits of the source register value or from the literal source-address field of the instruction.

After a fixed four-cycle latency the block pulses `done_o`. In that same cycle it presents a write-back request for the register file: enable, 9-bit address and data. The zero and carry flags are registered outputs. Each flag is reloaded only when its own effect bit in the instruction is set; otherwise it keeps its previous value. The carry flag takes bit 0 of the operand as it was before the shift, not the last bit shifted out. The 4-bit condition field is passed through unevaluated, alongside the result.

Top module: `sra_exec_unit`

## Requirements
- R1: `wr_data_o` equals the destination operand shifted right by the count, with every vacated high bit a copy of operand bit 31. Examples: -100 by 1, 2 and 3 gives -50, -25 and -13. 0x7FFFFFFF by 31 gives 0. 0x80000000 by 31 gives 0xFFFFFFFF.
- R2: The instruction is laid out as opcode [31:26], zero-effect [25], carry-effect [24], write-effect [23], immediate [22], condition [21:18], destination address [17:9] and source field [8:0]. With bit 22 set, the count is instruction bits [4:0]. With bit 22 clear, the count is `src_val_i[4:0]`, and bits [31:5] of `src_val_i` have no effect.
- R3: A count of 0 returns the operand unchanged. The flags are still computed from that unchanged result.
- R4: When bit 25 is set, `z_flag_o` becomes 1 if the result is zero and 0 otherwise.
- R5: When bit 24 is set, `c_flag_o` becomes bit 0 of the destination operand as it was before the shift.
- R6: A flag whose effect bit is clear keeps its previous value.
- R7: `wr_en_o` is high together with `done_o` only when bit 23 is set. `wr_addr_o` shows instruction bits [17:9] and `wr_data_o` shows the result.
- R8: `done_o` is high for exactly one cycle, three rising edges after the edge that samples the start pulse, so the start cycle counts as cycle one of four. `wr_en_o` is never high without `done_o`.
- R9: A start pulse that arrives while an operation is in flight is ignored.
- R10: A start pulse whose bits [31:26] differ from 001110 is ignored: no done, no write and no flag change.
- R11: `cond_o` shows instruction bits [21:18] of the finished operation from the `done_o` cycle on.
- R12: After a synchronous reset, `done_o`, `wr_en_o`, `z_flag_o` and `c_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to execute `instr_i` |
| instr_i | input | 32 | Instruction word |
| dst_val_i | input | 32 | Current value of the destination register |
| src_val_i | input | 32 | Current value of the source register |
| done_o | output | 1 | Completion pulse |
| wr_en_o | output | 1 | Register write-back enable |
| wr_addr_o | output | 9 | Write-back register address |
| wr_data_o | output | 32 | Shift result |
| z_flag_o | output | 1 | Zero flag |
| c_flag_o | output | 1 | Carry flag |
| cond_o | output | 4 | Condition field of the finished operation |

## Verification
The hardest situations to reach are those where a flag must visibly not change, and those where a second start is dropped. A flag hold only shows at the ports if the flag was first forced to the value opposite to what the new result would produce. The bench therefore sets both flags with one operation and then issues an operation whose result would clear them with the effect bits off. For the busy case, a second start carrying a different destination address is driven on the cycle right after the first. The bench then watches for a stray done pulse or a wrong address over several cycles. A wrong-opcode start is made to carry a zero result with the zero-effect bit set, so that any leak would show on the flag.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned COND_W  = 4;
  localparam int unsigned OPC_W   = 6;
  localparam logic [OPC_W-1:0] OPC_SAR = 6'b001110;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              upd_z;
    logic              upd_c;
    logic              wr;
    logic              imm;
    logic [COND_W-1:0] cond;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } instr_t;

  function automatic logic is_sar(input instr_t ir);
    return ir.opc == OPC_SAR;
  endfunction
endpackage

// File: rtl/sar_decode.sv
module sar_decode
  import sar_pkg::*;
#(
  parameter int unsigned SH_W = 5
) (
  input  instr_t              ir_i,
  input  logic [SH_W-1:0]     reg_amt_i,
  output logic [SH_W-1:0]     amt_o,
  output logic                upd_z_o,
  output logic                upd_c_o,
  output logic                wr_o,
  output logic [ADDR_W-1:0]   dst_o,
  output logic [COND_W-1:0]   cond_o
);
  logic unused_src_hi;

  always_comb begin
    amt_o   = ir_i.imm ? ir_i.src[SH_W-1:0] : reg_amt_i;
    upd_z_o = ir_i.upd_z;
    upd_c_o = ir_i.upd_c;
    wr_o    = ir_i.wr;
    dst_o   = ir_i.dst;
    cond_o  = ir_i.cond;
  end

  assign unused_src_hi = ^{ir_i.src[ADDR_W-1:SH_W], ir_i.opc};
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] stg [0:SH_W];

  assign stg[0] = opnd_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stg[s+1] = amt_i[s]
      ? {{STEP{stg[s][DATA_W-1]}}, stg[s][DATA_W-1:STEP]}
      : stg[s];
  end

  assign res_o = stg[SH_W];

  always_comb begin
    if (!$isunknown(opnd_i)) begin
      // R1
      sign_keep_chk: assert (res_o[DATA_W-1] == opnd_i[DATA_W-1]);
    end
  end
endmodule

// File: rtl/sar_flags.sv
module sar_flags (
  input  logic clk,
  input  logic rst,
  input  logic z_en_i,
  input  logic z_val_i,
  input  logic c_en_i,
  input  logic c_val_i,
  output logic z_o,
  output logic c_o
);
  logic z_q, c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      if (z_en_i) z_q <= z_val_i;
      if (c_en_i) c_q <= c_val_i;
    end
  end

  assign z_o = z_q;
  assign c_o = c_q;

  // R6
  z_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !z_en_i |=> $stable(z_q));
  // R6
  c_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !c_en_i |=> $stable(c_q));
  // R5
  c_load_chk: assert property (@(posedge clk) disable iff (rst)
    c_en_i |=> (c_q == $past(c_val_i)));
endmodule

// File: rtl/sra_exec_unit.sv
module sra_exec_unit
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LATENCY = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [DATA_W-1:0]    dst_val_i,
  input  logic [DATA_W-1:0]    src_val_i,
  output logic                 done_o,
  output logic                 wr_en_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic                 z_flag_o,
  output logic                 c_flag_o,
  output logic [COND_W-1:0]    cond_o
);
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned CNT_W = $clog2(LATENCY);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 2);
  localparam logic [CNT_W-1:0] LMAX = CNT_W'(LATENCY - 1);

  instr_t            ir_q;
  logic [DATA_W-1:0] opnd_q;
  logic [SH_W-1:0]   ramt_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept, finish;
  logic unused_src_hi;

  logic [SH_W-1:0]   amt;
  logic              upd_z, upd_c, wr;
  logic [ADDR_W-1:0] dst;
  logic [COND_W-1:0] cond;
  logic [DATA_W-1:0] res;

  logic              done_q, wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [COND_W-1:0] cond_q;

  assign accept = start_i && !busy_q && is_sar(instr_t'(instr_i));
  assign finish = busy_q && (cnt_q == LAST);
  assign unused_src_hi = ^src_val_i[DATA_W-1:SH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      busy_q <= !finish;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ir_q   <= instr_t'(instr_i);
      opnd_q <= dst_val_i;
      ramt_q <= src_val_i[SH_W-1:0];
    end
  end

  sar_decode #(.SH_W(SH_W)) u_dec (
    .ir_i      (ir_q),
    .reg_amt_i (ramt_q),
    .amt_o     (amt),
    .upd_z_o   (upd_z),
    .upd_c_o   (upd_c),
    .wr_o      (wr),
    .dst_o     (dst),
    .cond_o    (cond)
  );

  sar_shifter #(.DATA_W(DATA_W)) u_shf (
    .opnd_i (opnd_q),
    .amt_i  (amt),
    .res_o  (res)
  );

  sar_flags u_flg (
    .clk     (clk),
    .rst     (rst),
    .z_en_i  (finish && upd_z),
    .z_val_i (res == '0),
    .c_en_i  (finish && upd_c),
    .c_val_i (opnd_q[0]),
    .z_o     (z_flag_o),
    .c_o     (c_flag_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      cond_q    <= '0;
    end else begin
      done_q  <= finish;
      wr_en_q <= finish && wr;
      if (finish) begin
        wr_addr_q <= dst;
        wr_data_q <= res;
        cond_q    <= cond;
      end
    end
  end

  assign done_o    = done_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign cond_o    = cond_q;

  // checker-side age counter, independent of cnt_q
  logic [CNT_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                          age_q <= '0;
    else if (accept)                  age_q <= CNT_W'(1);
    else if (age_q != '0 && age_q != LMAX) age_q <= age_q + 1'b1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8
  wr_in_done_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> done_o);
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (age_q == LMAX));
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !finish) |=> busy_q);
endmodule

// File: tb/sim_sra_exec_unit.sv
module sim_sra_exec_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] instr, dval, sval;
  logic        done_o, wr_en_o, z_flag_o, c_flag_o;
  logic [8:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic [3:0]  cond_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sra_exec_unit u0 (
    .clk(clk), .rst(rst), .start_i(start), .instr_i(instr),
    .dst_val_i(dval), .src_val_i(sval), .done_o(done_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .z_flag_o(z_flag_o),
    .c_flag_o(c_flag_o), .cond_o(cond_o)
  );

  localparam logic [5:0] OPC = 6'b001110;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic wz, input logic wc,
      input logic wr, input logic im, input logic [3:0] cd, input logic [8:0] da,
      input logic [8:0] sf);
    return {op, wz, wc, wr, im, cd, da, sf};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives one start; returns done seen early / on the fourth cycle
  task automatic issue(input logic [31:0] iw, input logic [31:0] dv, input logic [31:0] sv,
      output logic early, output logic ontime);
    @(negedge clk); start = 1'b1; instr = iw; dval = dv; sval = sv;
    @(negedge clk); start = 1'b0; early = done_o;
    for (int i = 0; i < 2; i++) begin @(negedge clk); early = early | done_o; end
    @(negedge clk); ontime = done_o;
  endtask

  task automatic op_chk(input string req, input logic [31:0] iw, input logic [31:0] dv,
      input logic [31:0] sv, input logic [31:0] exp_d, input logic exp_z, input logic exp_c);
    logic e, o;
    issue(iw, dv, sv, e, o);
    chk({req, " done"}, {31'b0, o & ~e}, 32'd1);
    chk({req, " data"}, wr_data_o, exp_d);
    chk({req, " z/c"}, {30'b0, z_flag_o, c_flag_o}, {30'b0, exp_z, exp_c});
  endtask

  task automatic t_reset;
    chk("R12 reset outs", {28'b0, done_o, wr_en_o, z_flag_o, c_flag_o}, 32'd0);
  endtask

  task automatic t_vectors;
    op_chk("R1 R4 R5 -100>>1", mk(OPC,1,1,1,1,4'h0,9'h011,9'd1), 32'hFFFFFF9C, 0, 32'hFFFFFFCE, 0, 0);
    op_chk("R1 -100>>2", mk(OPC,1,1,1,1,4'h0,9'h011,9'd2), 32'hFFFFFF9C, 0, 32'hFFFFFFE7, 0, 0);
    op_chk("R1 -100>>3 reg", mk(OPC,1,1,1,0,4'h0,9'h011,9'd0), 32'hFFFFFF9C, 32'd3, 32'hFFFFFFF3, 0, 0);
    op_chk("R5 -13>>1", mk(OPC,1,1,1,1,4'h0,9'h011,9'd1), 32'hFFFFFFF3, 0, 32'hFFFFFFF9, 0, 1);
    op_chk("R5 -4>>1", mk(OPC,1,1,1,1,4'h0,9'h011,9'd1), 32'hFFFFFFFC, 0, 32'hFFFFFFFE, 0, 0);
    op_chk("R4 6>>3", mk(OPC,1,1,1,1,4'h0,9'h011,9'd3), 32'd6, 0, 32'd0, 1, 0);
    chk("R7 wr_addr", {23'b0, wr_addr_o}, 32'h011);
  endtask

  task automatic t_count_src;
    op_chk("R2 imm count", mk(OPC,0,0,1,1,4'h0,9'h020,9'd5), 32'h80000000, 32'd1, 32'hFC000000, 1, 0);
    op_chk("R2 reg count hi ignored", mk(OPC,0,0,1,0,4'h0,9'h020,9'd9), 32'h80000000, 32'hFFFFFF24, 32'hF8000000, 1, 0);
  endtask

  task automatic t_edges;
    op_chk("R3 zero count", mk(OPC,1,1,1,1,4'h0,9'h001,9'd0), 32'h80000001, 0, 32'h80000001, 0, 1);
    op_chk("R3 zero count zero val", mk(OPC,1,1,1,1,4'h0,9'h001,9'd0), 32'd0, 0, 32'd0, 1, 0);
    op_chk("R1 pos by 31", mk(OPC,1,1,1,1,4'h0,9'h001,9'd31), 32'h7FFFFFFF, 0, 32'd0, 1, 1);
    op_chk("R1 neg by 31", mk(OPC,1,1,1,1,4'h0,9'h001,9'd31), 32'h80000000, 0, 32'hFFFFFFFF, 0, 0);
  endtask

  task automatic t_hold;
    op_chk("R6 set flags", mk(OPC,1,1,1,1,4'h0,9'h002,9'd1), 32'd1, 0, 32'd0, 1, 1);
    op_chk("R6 both held", mk(OPC,0,0,1,1,4'h0,9'h002,9'd0), 32'd2, 0, 32'd2, 1, 1);
    op_chk("R6 c held z upd", mk(OPC,1,0,1,1,4'h0,9'h002,9'd0), 32'd2, 0, 32'd2, 0, 1);
  endtask

  task automatic t_write;
    logic e, o;
    issue(mk(OPC,0,0,0,1,4'h0,9'h0AB,9'd1), 32'd8, 0, e, o);
    chk("R7 no write en", {30'b0, done_o, wr_en_o}, 32'b10);
    chk("R7 result still shown", wr_data_o, 32'd4);
    issue(mk(OPC,0,0,1,1,4'hA,9'h1C3,9'd1), 32'd8, 0, e, o);
    chk("R7 write en", {30'b0, done_o, wr_en_o}, 32'b11);
    chk("R7 addr", {23'b0, wr_addr_o}, 32'h1C3);
    chk("R11 cond", {28'b0, cond_o}, 32'hA);
    @(negedge clk);
    chk("R8 done one cycle", {30'b0, done_o, wr_en_o}, 32'b0);
  endtask

  task automatic t_busy;
    int extra = 0;
    @(negedge clk); start = 1'b1; instr = mk(OPC,0,0,1,1,4'h0,9'h044,9'd2); dval = 32'd16; sval = 0;
    @(negedge clk); instr = mk(OPC,1,1,1,1,4'h0,9'h055,9'd0); dval = 32'd0;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 first done", {31'b0, done_o}, 32'd1);
    chk("R9 first addr", {23'b0, wr_addr_o}, 32'h044);
    chk("R9 first data", wr_data_o, 32'd4);
    for (int i = 0; i < 6; i++) begin @(negedge clk); extra += done_o; end
    chk("R9 second start dropped", extra, 32'd0);
    chk("R9 flags untouched", {30'b0, z_flag_o, c_flag_o}, {30'b0, 1'b0, 1'b1});
  endtask

  task automatic t_badop;
    int seen = 0;
    @(negedge clk); start = 1'b1; instr = mk(6'b001111,1,1,1,1,4'h0,9'h077,9'd0); dval = 32'd0;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); seen += done_o + wr_en_o; end
    chk("R10 bad opcode no done", seen, 32'd0);
    chk("R10 bad opcode flags", {30'b0, z_flag_o, c_flag_o}, {30'b0, 1'b0, 1'b1});
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; instr = '0; dval = '0; sval = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_count_src();
    t_edges();
    t_hold();
    t_write();
    t_busy();
    t_badop();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule